// File: doc/BRIEF.md
# Triangle Wave Tone Voice

This block is one voice of a sound generator. It produces a 4-bit sample that ramps down from 15 to 0 and then back up to 15, over and over. The pitch is set by an 11-bit period register, and the note length is set by two countdown counters. Software configures the voice through three byte-wide write registers. A level enable input, taken from a shared channel-enable register, controls whether the note-length counter may be loaded.

Two strobes drive the voice from outside. A quarter-frame strobe clocks a 7-bit linear counter, which sets a fine note duration. A half-frame strobe clocks a note-length counter, which is loaded from a lookup table passed in as a parameter. The voice sounds only while both counters are nonzero. One control bit does two jobs: it freezes the length counter, and it keeps the linear counter reloading on every quarter-frame strobe, so the note can be held forever. A status output reports whether the length counter is still running.

Top module: `tri_voice`

## Requirements
- R1: After reset, all counters, flags, the period and the sequence index are zero, so `sample` is 0 and `len_active` is 0.
- R2: While enabled to run, the output steps through a 32-entry sequence. Index k gives the value 15-k for k from 0 to 15, and k-16 for k from 16 to 31. After index 31 the sequence wraps to index 0.
- R3: The period timer is clocked every cycle. When the timer is zero, it reloads the 11-bit period and advances the sequence index. Otherwise it decrements. So a running sequence advances once every period+1 cycles.
- R4: The timer and the sequence index hold their values while either the length counter or the linear counter is zero, and `sample` is then 0.
- R5: On a quarter-frame strobe with the reload flag clear, a nonzero linear counter decrements. When it reaches zero, the voice goes silent.
- R6: On a quarter-frame strobe with the reload flag set, the linear counter loads the 7-bit reload value. The reload flag is cleared on that strobe only when the control bit is 0. While the control bit is 1, the length counter does not count down.
- R7: A write with `wr_sel`=2 loads the length counter from table entry `wr_data[7:3]` only while `enable` is 1. The same write while disabled leaves the length counter unchanged.
- R8: On a half-frame strobe with the control bit 0, a nonzero length counter decrements. `len_active` is 1 exactly when the length counter is nonzero.
- R9: While `enable` is 0, the length counter is forced to 0.
- R10: A write with `wr_sel`=2 resets the sequence index to 0, reloads the timer with the new period, and sets the linear reload flag.
- R11: Register select: `wr_sel`=0 writes the reload value in bits 6:0 and the control bit in bit 7. `wr_sel`=1 writes period bits 7:0. `wr_sel`=2 writes period bits 10:8 from `wr_data[2:0]`. A write with `wr_sel`=3 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one timer step per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 setup, 1 period low, 2 length and period high, 3 none) |
| wr_data | input | 8 | Write data |
| enable | input | 1 | Channel enable bit from the shared enable register |
| qtr_tick | input | 1 | Quarter-frame strobe for the linear counter |
| half_tick | input | 1 | Half-frame strobe for the length counter |
| len_active | output | 1 | High while the length counter is nonzero |
| sample | output | 4 | Current 4-bit output sample |

## Verification
The bench keeps the default 11-bit period, so the three high period bits can be exercised directly. A period of 258 checks that the high byte takes part in the reload, and a period of 2047 holds the output steady while counter behaviour is observed. The bench replaces the length table with one whose entry k holds k+1. This makes each loaded length small and exactly predictable, so the number of half-frame strobes needed to reach silence can be counted. A period of 0 advances the sequence every cycle, so all 32 sequence values and the wrap back to index 0 can be seen.

// File: rtl/tri_pkg.sv
package tri_pkg;
    localparam int SEQ_W = 5;

    typedef enum logic [1:0] {
        SEL_SETUP = 2'd0,
        SEL_PLO   = 2'd1,
        SEL_LEN   = 2'd2,
        SEL_NONE  = 2'd3
    } tri_sel_e;

    // Ramp down over the first half of the index range, then up.
    function automatic logic [SEQ_W-2:0] tri_level(input logic [SEQ_W-1:0] idx);
        return idx[SEQ_W-1] ? idx[SEQ_W-2:0] : ~idx[SEQ_W-2:0];
    endfunction
endpackage

// File: rtl/tri_timer.sv
module tri_timer #(
    parameter int PERIOD_W = 11,
    parameter int SEQ_W    = 5,
    localparam int HI_W    = PERIOD_W - 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                lo_we,
    input  logic [7:0]          lo_data,
    input  logic                hi_we,
    input  logic [HI_W-1:0]     hi_data,
    output logic [SEQ_W-1:0]    seq_idx,
    output logic [PERIOD_W-1:0] timer_cnt
);
    typedef struct packed {
        logic [PERIOD_W-1:0] period;
        logic [PERIOD_W-1:0] cnt;
        logic [SEQ_W-1:0]    idx;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lo_we) begin
            st_d.period[7:0] = lo_data;
        end
        if (hi_we) begin
            st_d.period[PERIOD_W-1:8] = hi_data;
            st_d.cnt = {hi_data, st_q.period[7:0]};
            st_d.idx = '0;
        end else if (run) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = st_q.period;
                st_d.idx = st_q.idx + 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seq_idx   = st_q.idx;
    assign timer_cnt = st_q.cnt;
endmodule

// File: rtl/tri_linear.sv
module tri_linear #(
    parameter int LIN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_we,
    input  logic [LIN_W-1:0] reload_in,
    input  logic             ctrl_in,
    input  logic             restart,
    input  logic             qtr_tick,
    output logic             hold,
    output logic [LIN_W-1:0] lin_cnt
);
    typedef struct packed {
        logic [LIN_W-1:0] reload;
        logic             ctrl;
        logic             flag;
        logic [LIN_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (setup_we) begin
            st_d.reload = reload_in;
            st_d.ctrl   = ctrl_in;
        end
        if (qtr_tick) begin
            if (st_q.flag)             st_d.cnt = st_q.reload;
            else if (st_q.cnt != '0)   st_d.cnt = st_q.cnt - 1'b1;
            if (!st_q.ctrl)            st_d.flag = 1'b0;
        end
        // a restart in the same cycle wins over the clear
        if (restart) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold    = st_q.ctrl;
    assign lin_cnt = st_q.cnt;
endmodule

// File: rtl/tri_length.sv
module tri_length #(
    parameter int                             LEN_W     = 8,
    parameter int                             IDX_W     = 5,
    parameter logic [(1<<IDX_W)*LEN_W-1:0]    LEN_TABLE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             load_we,
    input  logic [IDX_W-1:0] load_idx,
    input  logic             half_tick,
    input  logic             halt,
    output logic [LEN_W-1:0] len_cnt
);
    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.cnt = '0;
        end else if (load_we) begin
            st_d.cnt = LEN_TABLE[load_idx*LEN_W +: LEN_W];
        end else if (half_tick && !halt && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign len_cnt = st_q.cnt;
endmodule

// File: rtl/tri_voice.sv
module tri_voice
    import tri_pkg::*;
#(
    parameter int                          PERIOD_W  = 11,
    parameter int                          LIN_W     = 7,
    parameter int                          LEN_W     = 8,
    parameter int                          IDX_W     = 5,
    parameter logic [(1<<IDX_W)*LEN_W-1:0] LEN_TABLE = {
        8'd30, 8'd32, 8'd28, 8'd16, 8'd26, 8'd72, 8'd24, 8'd192,
        8'd22, 8'd96, 8'd20, 8'd48, 8'd18, 8'd24, 8'd16, 8'd12,
        8'd14, 8'd26, 8'd12, 8'd14, 8'd10, 8'd60, 8'd8,  8'd160,
        8'd6,  8'd80, 8'd4,  8'd40, 8'd2,  8'd20, 8'd254, 8'd10
    }
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       enable,
    input  logic       qtr_tick,
    input  logic       half_tick,
    output logic       len_active,
    output logic [3:0] sample
);
    localparam int HI_W = PERIOD_W - 8;

    tri_sel_e sel;
    logic     we_setup, we_plo, we_len;
    logic     hold, voiced;

    logic [SEQ_W-1:0]    seq_idx;
    logic [PERIOD_W-1:0] timer_cnt;
    logic [LIN_W-1:0]    lin_cnt;
    logic [LEN_W-1:0]    len_cnt;

    assign sel      = tri_sel_e'(wr_sel);
    assign we_setup = wr_en && (sel == SEL_SETUP);
    assign we_plo   = wr_en && (sel == SEL_PLO);
    assign we_len   = wr_en && (sel == SEL_LEN);

    assign voiced = (len_cnt != '0) && (lin_cnt != '0);

    tri_timer #(.PERIOD_W(PERIOD_W), .SEQ_W(SEQ_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (voiced),
        .lo_we     (we_plo),
        .lo_data   (wr_data),
        .hi_we     (we_len),
        .hi_data   (wr_data[HI_W-1:0]),
        .seq_idx   (seq_idx),
        .timer_cnt (timer_cnt)
    );

    tri_linear #(.LIN_W(LIN_W)) u_linear (
        .clk       (clk),
        .rst_n     (rst_n),
        .setup_we  (we_setup),
        .reload_in (wr_data[LIN_W-1:0]),
        .ctrl_in   (wr_data[7]),
        .restart   (we_len),
        .qtr_tick  (qtr_tick),
        .hold      (hold),
        .lin_cnt   (lin_cnt)
    );

    tri_length #(.LEN_W(LEN_W), .IDX_W(IDX_W), .LEN_TABLE(LEN_TABLE)) u_length (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .load_we   (we_len),
        .load_idx  (wr_data[7 -: IDX_W]),
        .half_tick (half_tick),
        .halt      (hold),
        .len_cnt   (len_cnt)
    );

    assign len_active = (len_cnt != '0);
    assign sample     = voiced ? tri_level(seq_idx) : 4'd0;
endmodule

// File: rtl/tri_voice_chk.sv
module tri_voice_chk #(
    parameter int PERIOD_W = 11,
    parameter int LIN_W    = 7,
    parameter int LEN_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [1:0]          wr_sel,
    input logic                enable,
    input logic [4:0]          seq_idx,
    input logic [PERIOD_W-1:0] timer_cnt,
    input logic [LIN_W-1:0]    lin_cnt,
    input logic [LEN_W-1:0]    len_cnt
);
    logic       wr_len;
    logic       gated;
    logic [4:0] idx_inc;

    assign wr_len  = wr_en && (wr_sel == 2'd2);
    assign gated   = (len_cnt == '0) || (lin_cnt == '0);
    assign idx_inc = seq_idx + 5'd1;

    // R9
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (len_cnt == '0));

    // R4
    a_r4_gate_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (gated && !wr_len) |=> ($stable(seq_idx) && $stable(timer_cnt)));

    // R2
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_len |=> ((seq_idx == $past(seq_idx)) || (seq_idx == $past(idx_inc))));

    // R8
    a_r8_len_only_falls: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_len |=> (len_cnt <= $past(len_cnt)));

    // R10
    a_r10_restart_index: assert property (@(posedge clk) disable iff (!rst_n)
        wr_len |=> (seq_idx == 5'd0));
endmodule

bind tri_voice tri_voice_chk #(
    .PERIOD_W (PERIOD_W),
    .LIN_W    (LIN_W),
    .LEN_W    (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .enable    (enable),
    .seq_idx   (seq_idx),
    .timer_cnt (timer_cnt),
    .lin_cnt   (lin_cnt),
    .len_cnt   (len_cnt)
);

// File: tb/tri_voice_tb.sv
module tri_voice_tb;
    function automatic logic [255:0] mk_table();
        logic [255:0] t;
        for (int k = 0; k < 32; k++) t[k*8 +: 8] = 8'(k + 1);
        return t;
    endfunction

    localparam logic [255:0] TB_TABLE = mk_table();

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       enable = 1'b0;
    logic       qtr_tick = 1'b0;
    logic       half_tick = 1'b0;
    logic       len_active;
    logic [3:0] sample;

    int n_checks = 0;
    int n_fails  = 0;

    tri_voice #(.LEN_TABLE(TB_TABLE)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .enable     (enable),
        .qtr_tick   (qtr_tick),
        .half_tick  (half_tick),
        .len_active (len_active),
        .sample     (sample)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; enable = 1'b0; wr_en = 1'b0; qtr_tick = 1'b0; half_tick = 1'b0;
        cycles(2);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic qtr();
        @(negedge clk); qtr_tick = 1'b1;
        @(negedge clk); qtr_tick = 1'b0;
    endtask

    task automatic half();
        @(negedge clk); half_tick = 1'b1;
        @(negedge clk); half_tick = 1'b0;
    endtask

    function automatic int seq_val(input int k);
        return (k < 16) ? 15 - k : k - 16;
    endfunction

    task automatic t_reset();
        do_reset();
        check("R1 sample after reset", sample, 0);
        check("R1 status after reset", len_active, 0);
    endtask

    task automatic t_gate_period();
        do_reset();
        enable = 1'b1;
        wr(2'd0, 8'h05);
        wr(2'd1, 8'h02);
        wr(2'd2, 8'h11);                 // index 2 -> length 3, period 0x102
        check("R7 length loaded", len_active, 1);
        check("R4 silent while linear zero", sample, 0);
        cycles(5);
        check("R4 held while linear zero", sample, 0);
        qtr();
        check("R4 sounds once both nonzero", sample, 15);
        cycles(258);
        check("R3 no step before period+1", sample, 15);
        cycles(1);
        check("R3 step after period+1 (R11 high bits)", sample, 14);
    endtask

    task automatic t_shape();
        do_reset();
        enable = 1'b1;
        wr(2'd0, 8'h0A);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h10);
        qtr();
        check("R2 index 0", sample, 15);
        for (int k = 1; k <= 32; k++) begin
            cycles(1);
            check($sformatf("R2 index %0d", k % 32), sample, seq_val(k % 32));
        end
    endtask

    task automatic t_linear();
        do_reset();
        enable = 1'b1;
        wr(2'd0, 8'h02);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h27);                 // index 4 -> length 5, period 2047
        qtr();
        check("R6 linear loaded", sample, 15);
        qtr();
        check("R5 linear 1 still sounds", sample, 15);
        wr(2'd2, 8'h27);
        check("R10 restart at index 0", sample, 15);
        qtr();
        check("R10 flag set reloads linear", sample, 15);
        qtr();
        check("R5 linear 1 after reload", sample, 15);
        qtr();
        check("R5 linear reaches zero", sample, 0);
        check("R5 length untouched", len_active, 1);
    endtask

    task automatic t_control();
        do_reset();
        enable = 1'b1;
        wr(2'd0, 8'h83);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h07);                 // index 0 -> length 1
        repeat (5) qtr();
        check("R6 control keeps linear reloading", sample, 15);
        repeat (6) half();
        check("R6 control halts length", len_active, 1);
        wr(2'd0, 8'h03);
        half();
        check("R8 length counts once control clear", len_active, 0);
        check("R8 silent at length zero", sample, 0);
    endtask

    task automatic t_length();
        do_reset();
        enable = 1'b0;
        wr(2'd2, 8'h18);                 // index 3
        check("R7 load ignored while disabled", len_active, 0);
        @(negedge clk); enable = 1'b1;
        cycles(1);
        check("R7 enable alone loads nothing", len_active, 0);
        wr(2'd2, 8'h18);                 // length 4
        check("R7 load while enabled", len_active, 1);
        repeat (3) half();
        check("R8 length 1 remains", len_active, 1);
        half();
        check("R8 length reaches zero", len_active, 0);
        half();
        check("R8 no underflow", len_active, 0);
    endtask

    task automatic t_disable();
        do_reset();
        enable = 1'b1;
        wr(2'd2, 8'hF8);                 // index 31 -> length 32
        check("R9 loaded before disable", len_active, 1);
        @(negedge clk); enable = 1'b0;
        @(negedge clk); enable = 1'b1;
        check("R9 disable clears length", len_active, 0);
    endtask

    task automatic t_sel3();
        do_reset();
        enable = 1'b1;
        wr(2'd0, 8'h04);
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'h3F);
        qtr();
        check("R11 running before sel 3", sample, 15);
        wr(2'd3, 8'h00);
        check("R11 sel 3 leaves sample", sample, 15);
        check("R11 sel 3 leaves length", len_active, 1);
    endtask

    initial begin
        t_reset();
        t_gate_period();
        t_shape();
        t_linear();
        t_control();
        t_length();
        t_disable();
        t_sel3();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule